// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the receive byte stream of an Ethernet MAC and decides, for every frame, whether it is kept or thrown away. It gathers the destination address from the first six bytes of the frame and compares it against a set of match sources. These sources are a primary station address, a build-time number of extra station addresses, the general multicast class, the all-ones broadcast address and the reserved flow-control (pause) address. Each source is switched on or off on its own.

When no source is switched on, the filter is transparent and every frame of full address length passes. A one-byte-per-beat stream with start, end and valid markers drives the block. It reports a held keep/reject verdict for the frame in progress and a single-cycle drop strobe once a rejected frame has ended. The configuration is sampled on the first beat of each frame, so a frame already in flight is judged by the settings in force when it began.

Top module: `eth_da_filter`

## Requirements
- R1: The destination address is the first six beats of a frame. The first beat (the one carrying `in_sof`) supplies address bits 47:40, and the sixth beat supplies bits 7:0.
- R2: When `cfg_pri_en` is 1, a destination equal to `cfg_pri_addr` is a match.
- R3: `SUPP_CNT` (0 to 4) extra address slots exist. Slot k sits in `cfg_supp_addr[48k+47:48k]` and is a match only while `cfg_supp_en[k]` is 1.
- R4: When `cfg_mc_en` is 1, any destination with address bit 40 set (bit 0 of the first byte) matches, except the all-ones address, which is never counted as general multicast.
- R5: When `cfg_bc_en` is 1, the all-ones destination matches.
- R6: When `cfg_pause_en` is 1, the destination 48'h0180C2000001 matches.
- R7: If at least one source is enabled and the destination matches no enabled source, the frame is rejected.
- R8: If no source is enabled, every frame of six or more bytes is accepted.
- R9: `dec_valid` rises in the cycle after the sixth beat and stays high up to and including the cycle in which the end beat is presented. If the end beat is the sixth beat, it stays high for exactly one cycle. `dec_accept` holds its value while `dec_valid` is high.
- R10: `drop_pulse` is high for one cycle, in the cycle after the end beat of a rejected frame. It never fires for an accepted frame.
- R11: A frame with fewer than six beats is rejected. `drop_pulse` fires in the cycle after its end beat, and `dec_valid` never rises for it.
- R12: Address and enable inputs are sampled on the start beat. Changes made later in the frame do not affect that frame's verdict.
- R13: Beats with `in_valid` high that arrive outside a frame (after an end beat and before the next start beat) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A data byte is present this cycle |
| in_sof | input | 1 | This beat is the first byte of a frame |
| in_eof | input | 1 | This beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_pri_addr | input | 48 | Primary station address |
| cfg_pri_en | input | 1 | Enable primary address match |
| cfg_supp_addr | input | 48*SLOTS | Extra station addresses, slot k in bits 48k+47:48k |
| cfg_supp_en | input | SLOTS | Per-slot enable for the extra addresses |
| cfg_mc_en | input | 1 | Accept general multicast destinations |
| cfg_bc_en | input | 1 | Accept the broadcast destination |
| cfg_pause_en | input | 1 | Accept the pause reserved destination |
| dec_valid | output | 1 | Verdict for the current frame is available |
| dec_accept | output | 1 | Verdict: 1 keep, 0 reject |
| drop_pulse | output | 1 | One-cycle strobe after a rejected frame ends |

## Verification
A byte counter that slips shows at once as an address built from the wrong bytes. The result is a wrong verdict one cycle after the sixth beat, or `dec_valid` rising a cycle early or late. A stale configuration snapshot shows as a verdict that follows mid-frame changes, which is visible in the same cycle the verdict appears. A wrong end-of-frame state shows in the cycle after the end beat: `dec_valid` stays high, the drop strobe is missing or doubled, or stray beats after the frame produce a verdict.

// File: rtl/eth_daf_pkg.sv
// Shared constants and types for the destination address filter.
// Assumes byte-wide frame beats and 48-bit station addresses.
package eth_daf_pkg;
    localparam int MAC_W    = 48;
    localparam int BYTE_W   = 8;
    localparam int DA_BYTES = MAC_W / BYTE_W;
    localparam int MC_BIT   = MAC_W - BYTE_W;   // bit 0 of the first byte on the wire

    localparam logic [MAC_W-1:0] BCAST_ADDR = '1;
    localparam logic [MAC_W-1:0] PAUSE_ADDR = 48'h0180_C200_0001;

    // Settings captured at the start of each frame
    typedef struct packed {
        logic [MAC_W-1:0] pri_addr;
        logic             pri_en;
        logic             mc_en;
        logic             bc_en;
        logic             pause_en;
    } base_cfg_t;
endpackage

// File: rtl/eth_daf_capture.sv
// Tracks frame position and gathers the destination address bytes.
// Assumes in_sof marks byte one; beats outside a frame are discarded.
// da_out is only meaningful in the cycle where sixth_beat is high.
module eth_daf_capture
    import eth_daf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_vld,
    input  logic              beat_sof,
    input  logic              beat_eof,
    input  logic [BYTE_W-1:0] beat_data,
    output logic              take,
    output logic              sixth_beat,
    output logic              short_end,
    output logic              frame_end,
    output logic [MAC_W-1:0]  da_out
);
    localparam int CNT_W   = $clog2(DA_BYTES + 1);
    localparam int SHIFT_W = MAC_W - BYTE_W;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   pos;
    logic [SHIFT_W-1:0] shift_q;
    logic               in_frame_q;

    // Classify the current beat by its position in the frame
    always_comb begin
        take       = beat_vld && (beat_sof || in_frame_q);
        pos        = beat_sof ? '0 : cnt_q;
        sixth_beat = take && (pos == CNT_W'(DA_BYTES - 1));
        frame_end  = take && beat_eof;
        short_end  = frame_end && (pos < CNT_W'(DA_BYTES - 1));
        da_out     = {shift_q, beat_data};
    end

    // Advance the byte counter, shift in address bytes, track frame state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shift_q    <= '0;
            in_frame_q <= 1'b0;
        end else if (take) begin
            shift_q    <= {shift_q[SHIFT_W-BYTE_W-1:0], beat_data};
            cnt_q      <= (pos == CNT_W'(DA_BYTES)) ? pos : pos + 1'b1;
            in_frame_q <= !beat_eof;
        end
    end
endmodule

// File: rtl/eth_daf_match.sv
// Compares a destination address against all enabled match sources.
// Purely combinational; returns keep=1 when nothing is enabled.
module eth_daf_match
    import eth_daf_pkg::*;
#(
    parameter int SUPP_CNT = 4,
    parameter int SLOTS    = (SUPP_CNT > 0) ? SUPP_CNT : 1
) (
    input  logic [MAC_W-1:0]       da,
    input  base_cfg_t              base,
    input  logic [SLOTS*MAC_W-1:0] supp_addr,
    input  logic [SLOTS-1:0]       supp_en,
    output logic                   keep,
    output logic                   any_en
);
    logic [SLOTS-1:0] supp_hit;
    logic             supp_on;
    logic             is_bc;
    logic             is_mc;
    logic             hit;

    generate
        if (SUPP_CNT > 0) begin : g_supp
            for (genvar k = 0; k < SUPP_CNT; k++) begin : g_slot
                // Per-slot exact compare
                assign supp_hit[k] = supp_en[k] && (da == supp_addr[k*MAC_W +: MAC_W]);
            end
            assign supp_on = |supp_en;
        end else begin : g_nosupp
            assign supp_hit = '0;
            assign supp_on  = 1'b0;
        end
    endgenerate

    // Combine the individual matches into the verdict
    always_comb begin
        is_bc  = (da == BCAST_ADDR);
        is_mc  = da[MC_BIT] && !is_bc;
        any_en = base.pri_en || supp_on || base.mc_en || base.bc_en || base.pause_en;
        hit    = (base.pri_en && (da == base.pri_addr))
              || (|supp_hit)
              || (base.mc_en && is_mc)
              || (base.bc_en && is_bc)
              || (base.pause_en && (da == PAUSE_ADDR));
        keep   = !any_en || hit;
    end
endmodule

// File: rtl/eth_da_filter.sv
// Receive-side destination address filter.
// Snapshots configuration on each start beat, judges the frame on its
// sixth beat, holds the verdict to the end beat and strobes on rejects.
// Assumes one byte per beat and that in_sof/in_eof qualify with in_valid.
module eth_da_filter
    import eth_daf_pkg::*;
#(
    parameter int SUPP_CNT = 4,
    parameter int SLOTS    = (SUPP_CNT > 0) ? SUPP_CNT : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic                   in_eof,
    input  logic [BYTE_W-1:0]      in_data,
    input  logic [MAC_W-1:0]       cfg_pri_addr,
    input  logic                   cfg_pri_en,
    input  logic [SLOTS*MAC_W-1:0] cfg_supp_addr,
    input  logic [SLOTS-1:0]       cfg_supp_en,
    input  logic                   cfg_mc_en,
    input  logic                   cfg_bc_en,
    input  logic                   cfg_pause_en,
    output logic                   dec_valid,
    output logic                   dec_accept,
    output logic                   drop_pulse
);
    logic                   take, sixth_beat, short_end, frame_end;
    logic [MAC_W-1:0]       da;
    base_cfg_t              base_q;
    logic [SLOTS*MAC_W-1:0] supp_addr_q;
    logic [SLOTS-1:0]       supp_en_q;
    logic                   keep;
    logic                   snap_any;
    logic                   dv_q, acc_q, drop_q, close_q;

    eth_daf_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_vld   (in_valid),
        .beat_sof   (in_sof),
        .beat_eof   (in_eof),
        .beat_data  (in_data),
        .take       (take),
        .sixth_beat (sixth_beat),
        .short_end  (short_end),
        .frame_end  (frame_end),
        .da_out     (da)
    );

    eth_daf_match #(.SUPP_CNT(SUPP_CNT), .SLOTS(SLOTS)) u_match (
        .da        (da),
        .base      (base_q),
        .supp_addr (supp_addr_q),
        .supp_en   (supp_en_q),
        .keep      (keep),
        .any_en    (snap_any)
    );

    // Capture the configuration on every accepted start beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            supp_addr_q <= '0;
            supp_en_q   <= '0;
        end else if (take && in_sof) begin
            base_q      <= '{pri_addr: cfg_pri_addr, pri_en: cfg_pri_en,
                             mc_en: cfg_mc_en, bc_en: cfg_bc_en,
                             pause_en: cfg_pause_en};
            supp_addr_q <= cfg_supp_addr;
            supp_en_q   <= cfg_supp_en;
        end
    end

    // Register the verdict, hold it through the frame, strobe on reject
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q    <= 1'b0;
            acc_q   <= 1'b0;
            drop_q  <= 1'b0;
            close_q <= 1'b0;
        end else begin
            drop_q <= frame_end && (short_end || (sixth_beat ? !keep : !acc_q));
            if (sixth_beat) begin
                dv_q    <= 1'b1;
                acc_q   <= keep;
                close_q <= in_eof;
            end else begin
                if (frame_end || close_q || (take && in_sof)) begin
                    dv_q <= 1'b0;
                end
                if (take && in_sof) begin
                    acc_q <= 1'b0;
                end
                close_q <= 1'b0;
            end
        end
    end

    assign dec_valid  = dv_q;
    assign dec_accept = acc_q;
    assign drop_pulse = drop_q;
endmodule

// File: rtl/eth_da_filter_chk.sv
// Temporal checks on the filter outputs, bound into eth_da_filter.
module eth_da_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_eof,
    input logic dec_valid,
    input logic dec_accept,
    input logic drop_pulse,
    input logic snap_any
);
    // R9
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && $past(dec_valid) |-> $stable(dec_accept));

    // R9
    verdict_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(in_valid));

    // R10
    drop_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> $past(in_valid && in_eof));

    // R10
    drop_is_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> !dec_accept);

    // R8
    open_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !snap_any |-> dec_accept);
endmodule

bind eth_da_filter eth_da_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_eof     (in_eof),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .drop_pulse (drop_pulse),
    .snap_any   (snap_any)
);

// File: tb/test_eth_da_filter.sv
module test_eth_da_filter;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic [47:0] pri_a = '0;
    logic        pri_en = 1'b0;
    logic [47:0] supp_a [NS];
    logic [NS-1:0] supp_en = '0;
    logic        mc_en = 1'b0, bc_en = 1'b0, pause_en = 1'b0;
    logic        dec_valid, dec_accept, drop_pulse;
    logic [NS*48-1:0] supp_flat;

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    assign supp_flat = {supp_a[3], supp_a[2], supp_a[1], supp_a[0]};

    eth_da_filter #(.SUPP_CNT(NS)) i_eth_da_filter (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .cfg_pri_addr(pri_a), .cfg_pri_en(pri_en),
        .cfg_supp_addr(supp_flat), .cfg_supp_en(supp_en),
        .cfg_mc_en(mc_en), .cfg_bc_en(bc_en), .cfg_pause_en(pause_en),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .drop_pulse(drop_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference verdict from the requirement list
    function automatic bit model(input logic [47:0] a);
        bit any, bc, mc, hit;
        any = pri_en || (|supp_en) || mc_en || bc_en || pause_en;
        bc  = (a == '1);
        mc  = a[40] && !bc;
        hit = (pri_en && a == pri_a) || (mc_en && mc) || (bc_en && bc)
           || (pause_en && a == 48'h0180C2000001);
        for (int k = 0; k < NS; k++) if (supp_en[k] && a == supp_a[k]) hit = 1'b1;
        return !any || hit;
    endfunction

    task automatic clear_cfg();
        pri_en = 0; supp_en = '0; mc_en = 0; bc_en = 0; pause_en = 0;
    endtask

    // Send one frame, checking outputs after every beat
    task automatic send(input logic [47:0] a, input int len, input bit gap,
                        input bit mid_clear, input string req);
        bit exp_acc;
        exp_acc = (len >= 6) && model(a);
        for (int i = 0; i < len; i++) begin
            bit edv, edrop;
            if (mid_clear && i == 2) begin
                clear_cfg(); bc_en = 1; pri_a = ~pri_a;
            end
            in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_data  = (i < 6) ? a[47 - 8*i -: 8] : 8'(i);
            @(negedge clk);
            edv   = (i >= 5) && (i == 5 || i < len - 1);
            edrop = (i == len - 1) && !exp_acc;
            chk(dec_valid == edv, req, "dec_valid", 48'(dec_valid), 48'(edv));
            if (edv) chk(dec_accept == exp_acc, req, "dec_accept", 48'(dec_accept), 48'(exp_acc));
            chk(drop_pulse == edrop, req, "drop_pulse", 48'(drop_pulse), 48'(edrop));
            if (gap && i == 2) begin
                in_valid = 0;
                @(negedge clk);
                chk(dec_valid == 1'b0 && drop_pulse == 1'b0, req, "idle gap",
                    48'({dec_valid, drop_pulse}), 48'(0));
            end
        end
        in_valid = 0; in_sof = 0; in_eof = 0;
        @(negedge clk);
        chk(dec_valid == 1'b0 && drop_pulse == 1'b0, req, "after frame",
            48'({dec_valid, drop_pulse}), 48'(0));
    endtask

    task automatic t_reset();
        chk(dec_valid == 0 && dec_accept == 0 && drop_pulse == 0, "R9", "reset state",
            48'({dec_valid, dec_accept, drop_pulse}), 48'(0));
    endtask

    task automatic t_primary();   // R2 R7 R1
        clear_cfg(); pri_a = 48'h0012_3456_789A; pri_en = 1;
        send(48'h0012_3456_789A, 10, 0, 0, "R2");
        send(48'h0012_3456_789B, 10, 0, 0, "R7");
        send(48'h9A78_5634_1200, 10, 0, 0, "R1");
    endtask

    task automatic t_supp();      // R3
        clear_cfg();
        supp_a[0] = 48'h0200_0000_0010; supp_a[1] = 48'h0200_0000_0011;
        supp_a[2] = 48'h0200_0000_0012; supp_a[3] = 48'h0200_0000_0013;
        supp_en = 4'b1001;
        send(supp_a[3], 8, 0, 0, "R3");
        send(supp_a[0], 8, 0, 0, "R3");
        send(supp_a[1], 8, 0, 0, "R3");
    endtask

    task automatic t_mcast();     // R4
        clear_cfg(); mc_en = 1;
        send(48'h0100_5E00_0001, 9, 0, 0, "R4");
        send(48'hFFFF_FFFF_FFFF, 9, 0, 0, "R4");
        send(48'h0800_5E00_0001, 9, 0, 0, "R4");
    endtask

    task automatic t_bcast();     // R5
        clear_cfg(); bc_en = 1;
        send(48'hFFFF_FFFF_FFFF, 7, 0, 0, "R5");
        send(48'h0100_5E00_0001, 7, 0, 0, "R5");
    endtask

    task automatic t_pause();     // R6
        clear_cfg(); pause_en = 1;
        send(48'h0180_C200_0001, 8, 0, 0, "R6");
        send(48'h0180_C200_0002, 8, 0, 0, "R6");
    endtask

    task automatic t_open();      // R8
        clear_cfg();
        send(48'h00AA_BBCC_DDEE, 8, 0, 0, "R8");
        send(48'hFFFF_FFFF_FFFF, 6, 0, 0, "R8");
    endtask

    task automatic t_timing();    // R9 R10
        clear_cfg(); pri_a = 48'h0000_0000_0042; pri_en = 1;
        send(48'h0000_0000_0042, 6, 0, 0, "R9");
        send(48'h0000_0000_0043, 6, 0, 0, "R10");
        send(48'h0000_0000_0042, 12, 1, 0, "R9");
        send(48'h0000_0000_0044, 12, 1, 0, "R10");
    endtask

    task automatic t_short();     // R11
        clear_cfg();
        send(48'h0000_0000_0000, 3, 0, 0, "R11");
        send(48'hFFFF_FFFF_FFFF, 1, 0, 0, "R11");
        send(48'h0000_0000_0000, 5, 1, 0, "R11");
    endtask

    task automatic t_cfg_mid();   // R12
        clear_cfg(); pri_a = 48'h0000_1111_2222; pri_en = 1;
        send(48'h0000_1111_2222, 9, 0, 1, "R12");
        clear_cfg(); pri_en = 1; mc_en = 1;
        send(48'hFFFF_FFFF_FFFF, 9, 0, 1, "R12");
    endtask

    task automatic t_stray();     // R13
        clear_cfg(); bc_en = 1;
        send(48'hFFFF_FFFF_FFFF, 6, 0, 0, "R13");
        for (int i = 0; i < 8; i++) begin
            in_valid = 1; in_sof = 0; in_eof = (i == 7); in_data = 8'hFF;
            @(negedge clk);
            chk(dec_valid == 0 && drop_pulse == 0, "R13", "stray beat",
                48'({dec_valid, drop_pulse}), 48'(0));
        end
        in_valid = 0; in_eof = 0;
        @(negedge clk);
        chk(dec_valid == 0 && drop_pulse == 0, "R13", "after stray",
            48'({dec_valid, drop_pulse}), 48'(0));
    endtask

    initial begin
        for (int k = 0; k < NS; k++) supp_a[k] = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_primary();
        t_supp();
        t_mcast();
        t_bcast();
        t_pause();
        t_open();
        t_timing();
        t_short();
        t_cfg_mid();
        t_stray();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            runs++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule